// File: doc/BRIEF.md
# Halt Wake-Up Controller

This block lets a small 4-bit core park itself in a low-power halt state and decides when and where it resumes. The core presents a halt request, a 4-bit condition code and the address of the halt instruction. The code selects the wake source for that halt: the periodic carry of the built-in interval timer, an accepted interrupt, or both. A code that selects neither source is treated as a no-op, and the core keeps running.

The interval timer counts a 1 MHz tick input and raises a sticky carry flag once per selected period. Software clears the flag through a test-and-clear strobe. The interrupt side holds four request latches, four per-source enables and one global enable. When the core wakes, the block pulses `wake` for one cycle and presents a resume address. After a timer wake this is the instruction after the halt. After an interrupt wake it is that source's vector, and the instruction after the halt is offered as the return address.

Top module: `halt_wake_ctrl`

## Requirements
- R1: A halt request taken while running enters halt on the next clock edge only if the code has bit 0 and bit 2 clear and has bit 1 (timer wake) or bit 3 (interrupt wake) set. Any other code, for example 0000, 0101, 0100 or 0001, leaves `halted` low.
- R2: With one tick per cycle, the carry flag is set once every P ticks. P is 1000, 5000, 100000 or 250000 for `tmr_sel` values 0, 1, 2 and 3, and the interval counter restarts at each carry.
- R3: In timer-wake mode, `halted` falls, `wake` pulses and `carry_flag` rises on the same clock edge. At that point `to_vector` is 0, and `resume_pc` and `ret_pc` both equal the halt address plus one.
- R4: `carry_flag` stays set until `carry_test` is asserted, which clears it on the next edge. If a new carry occurs in the same cycle as `carry_test`, the flag stays set.
- R5: An interrupt is accepted only when the global enable, that source's enable and that source's pending latch are all set. A pending source that is not enabled, or any source while the global enable is clear, leaves the core halted.
- R6: An interrupt wake sets `to_vector` to 1 and `resume_pc` to VEC_BASE plus the source index. `ret_pc` is set to the halt address plus one.
- R7: Among eligible sources the lowest index wins. Accepting a source clears its pending latch and the global enable, and leaves the other pending latches unchanged.
- R8: A timer-only halt ignores interrupts, and an interrupt-only halt ignores timer carries.
- R9: A halt request made while already halted is ignored, so the captured halt address is kept.
- R10: After reset, `halted`, `wake`, `carry_flag`, `gie`, `irq_pending` and `irq_enable` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1mhz | input | 1 | One-cycle 1 MHz timebase tick |
| tmr_sel | input | 2 | Interval select (0: 1 ms, 1: 5 ms, 2: 100 ms, 3: 250 ms) |
| carry_test | input | 1 | Test-and-clear strobe for the carry flag |
| carry_flag | output | 1 | Sticky timer carry flag |
| halt_req | input | 1 | Halt instruction strobe |
| halt_code | input | 4 | Wake-condition code |
| halt_pc | input | PC_W | Address of the halt instruction |
| gie_set | input | 1 | Set global interrupt enable |
| gie_clr | input | 1 | Clear global interrupt enable |
| ien_wr | input | 1 | Write per-source enables |
| ien_wdata | input | NSRC | New per-source enable values |
| irq_req | input | NSRC | Interrupt request pulses |
| halted | output | 1 | Core is halted |
| wake | output | 1 | One-cycle wake pulse |
| resume_pc | output | PC_W | Address at which to resume |
| to_vector | output | 1 | Resume address is an interrupt vector |
| ret_pc | output | PC_W | Return address for the core to save |
| gie | output | 1 | Global interrupt enable |
| irq_pending | output | NSRC | Pending request latches |
| irq_enable | output | NSRC | Per-source enables |

## Verification
The assertions assume that `gie_set` and `gie_clr` are never asserted together. They also assume that a halt is requested only after any earlier wake has been consumed, and that the tick input, when present, is one clean cycle wide. The bench drives every strobe as a single-cycle pulse after a clock edge, never asserts both enable strobes in the same cycle, and holds `tick_1mhz` high so that each cycle stands for one microsecond. The longer intervals are represented by their select encodings only. The timing checks run on the 1000-tick and 5000-tick periods, which are short enough for a directed run.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
    localparam int HC_TMR_BIT = 1;
    localparam int HC_IRQ_BIT = 3;

    function automatic logic code_enters(input logic [3:0] c);
        return !c[0] && !c[2] && (c[HC_TMR_BIT] || c[HC_IRQ_BIT]);
    endfunction
endpackage

// File: rtl/hwc_timer.sv
module hwc_timer #(
    parameter int P0 = 1000,
    parameter int P1 = 5000,
    parameter int P2 = 100000,
    parameter int P3 = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] sel,
    input  logic       test_clr,
    output logic       carry,
    output logic       carry_evt
);
    localparam int PA    = (P0 > P1) ? P0 : P1;
    localparam int PB    = (P2 > P3) ? P2 : P3;
    localparam int PMAX  = (PA > PB) ? PA : PB;
    localparam int CNT_W = $clog2(PMAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             carry;
    } tmr_t;

    tmr_t s_q, s_d;
    logic [CNT_W-1:0] lim;
    logic             term;

    always_comb begin
        case (sel)
            2'd0:    lim = CNT_W'(P0);
            2'd1:    lim = CNT_W'(P1);
            2'd2:    lim = CNT_W'(P2);
            default: lim = CNT_W'(P3);
        endcase
        term = tick && (s_q.cnt >= lim - 1'b1);
        s_d  = s_q;
        if (term)      s_d.cnt = '0;
        else if (tick) s_d.cnt = s_q.cnt + 1'b1;
        s_d.carry = term || (s_q.carry && !test_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign carry     = s_q.carry;
    assign carry_evt = term;

    AST_CARRY_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        carry_evt |=> carry); // R4
    AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (test_clr && !carry_evt) |=> !carry); // R4
    AST_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !test_clr) |=> carry); // R4
endmodule

// File: rtl/hwc_irq.sv
module hwc_irq #(
    parameter int NSRC = 4,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gie_set,
    input  logic            gie_clr,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_wdata,
    input  logic [NSRC-1:0] req,
    input  logic            ack_allow,
    output logic            gie,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] en,
    output logic            ack_valid,
    output logic [IW-1:0]   ack_idx
);
    typedef struct packed {
        logic            gie;
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] en;
    } irq_t;

    irq_t s_q, s_d;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] ack_vec;

    always_comb begin
        elig    = s_q.pend & s_q.en & {NSRC{s_q.gie}};
        ack_idx = '0;
        ack_vec = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                ack_idx = IW'(i);
                ack_vec = NSRC'(1) << i;
            end
        end
        ack_valid = ack_allow && (elig != '0);
        if (!ack_valid) ack_vec = '0;

        s_d      = s_q;
        s_d.pend = (s_q.pend & ~ack_vec) | req;
        if (en_wr) s_d.en = en_wdata;
        if (ack_valid)    s_d.gie = 1'b0;
        else if (gie_clr) s_d.gie = 1'b0;
        else if (gie_set) s_d.gie = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gie  = s_q.gie;
    assign pend = s_q.pend;
    assign en   = s_q.en;

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_vec)); // R7
    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !gie); // R7
    AST_ACK_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (gie && pend[ack_idx] && en[ack_idx])); // R5
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import hwc_pkg::*;
#(
    parameter int              PC_W     = 12,
    parameter int              NSRC     = 4,
    parameter logic [PC_W-1:0] VEC_BASE = 12'hF00,
    parameter int              P0       = 1000,
    parameter int              P1       = 5000,
    parameter int              P2       = 100000,
    parameter int              P3       = 250000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_1mhz,
    input  logic [1:0]      tmr_sel,
    input  logic            carry_test,
    output logic            carry_flag,
    input  logic            halt_req,
    input  logic [3:0]      halt_code,
    input  logic [PC_W-1:0] halt_pc,
    input  logic            gie_set,
    input  logic            gie_clr,
    input  logic            ien_wr,
    input  logic [NSRC-1:0] ien_wdata,
    input  logic [NSRC-1:0] irq_req,
    output logic            halted,
    output logic            wake,
    output logic [PC_W-1:0] resume_pc,
    output logic            to_vector,
    output logic [PC_W-1:0] ret_pc,
    output logic            gie,
    output logic [NSRC-1:0] irq_pending,
    output logic [NSRC-1:0] irq_enable
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic            halted;
        logic            tmr_mode;
        logic            irq_mode;
        logic [PC_W-1:0] hpc;
        logic            wake;
        logic            tovec;
        logic [PC_W-1:0] resume;
        logic [PC_W-1:0] ret;
    } ctl_t;

    ctl_t s_q, s_d;
    logic carry_evt;
    logic ack_valid;
    logic [IW-1:0] ack_idx;

    hwc_timer #(.P0(P0), .P1(P1), .P2(P2), .P3(P3)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1mhz),
        .sel      (tmr_sel),
        .test_clr (carry_test),
        .carry    (carry_flag),
        .carry_evt(carry_evt)
    );

    hwc_irq #(.NSRC(NSRC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .gie_set  (gie_set),
        .gie_clr  (gie_clr),
        .en_wr    (ien_wr),
        .en_wdata (ien_wdata),
        .req      (irq_req),
        .ack_allow(s_q.halted && s_q.irq_mode),
        .gie      (gie),
        .pend     (irq_pending),
        .en       (irq_enable),
        .ack_valid(ack_valid),
        .ack_idx  (ack_idx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.wake = 1'b0;
        if (!s_q.halted) begin
            if (halt_req && code_enters(halt_code)) begin
                s_d.halted   = 1'b1;
                s_d.tmr_mode = halt_code[HC_TMR_BIT];
                s_d.irq_mode = halt_code[HC_IRQ_BIT];
                s_d.hpc      = halt_pc;
            end
        end else if (ack_valid) begin
            s_d.halted = 1'b0;
            s_d.wake   = 1'b1;
            s_d.tovec  = 1'b1;
            s_d.resume = VEC_BASE + PC_W'(ack_idx);
            s_d.ret    = s_q.hpc + 1'b1;
        end else if (s_q.tmr_mode && carry_evt) begin
            s_d.halted = 1'b0;
            s_d.wake   = 1'b1;
            s_d.tovec  = 1'b0;
            s_d.resume = s_q.hpc + 1'b1;
            s_d.ret    = s_q.hpc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign halted    = s_q.halted;
    assign wake      = s_q.wake;
    assign resume_pc = s_q.resume;
    assign to_vector = s_q.tovec;
    assign ret_pc    = s_q.ret;

    AST_NOOP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && halt_req && !code_enters(halt_code)) |=> !halted); // R1
    AST_WAKE_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(halted) && !halted)); // R3
    AST_TIMER_WAKE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !to_vector) |-> (carry_flag && resume_pc == ret_pc)); // R3
    AST_VEC_WAKE_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && to_vector) |-> ($past(gie) && !gie)); // R5
    AST_HALT_PC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> $stable(s_q.hpc)); // R9
endmodule

// File: tb/sim_halt_wake_ctrl.sv
module sim_halt_wake_ctrl;
    localparam int PC_W = 12;
    localparam int NSRC = 4;
    localparam logic [PC_W-1:0] VB = 12'hF00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1mhz = 1'b0;
    logic [1:0] tmr_sel = 2'd0;
    logic carry_test = 1'b0;
    logic carry_flag;
    logic halt_req = 1'b0;
    logic [3:0] halt_code = 4'd0;
    logic [PC_W-1:0] halt_pc = '0;
    logic gie_set = 1'b0, gie_clr = 1'b0, ien_wr = 1'b0;
    logic [NSRC-1:0] ien_wdata = '0, irq_req = '0;
    logic halted, wake, to_vector, gie;
    logic [PC_W-1:0] resume_pc, ret_pc;
    logic [NSRC-1:0] irq_pending, irq_enable;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    halt_wake_ctrl #(.PC_W(PC_W), .NSRC(NSRC), .VEC_BASE(VB)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_1mhz(tick_1mhz), .tmr_sel(tmr_sel),
        .carry_test(carry_test), .carry_flag(carry_flag), .halt_req(halt_req),
        .halt_code(halt_code), .halt_pc(halt_pc), .gie_set(gie_set),
        .gie_clr(gie_clr), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .irq_req(irq_req), .halted(halted), .wake(wake), .resume_pc(resume_pc),
        .to_vector(to_vector), .ret_pc(ret_pc), .gie(gie),
        .irq_pending(irq_pending), .irq_enable(irq_enable)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_carry(output int n);
        n = 0;
        while (carry_flag !== 1'b1) begin
            step();
            n++;
        end
    endtask

    task automatic clear_carry();
        carry_test = 1'b1;
        step();
        carry_test = 1'b0;
    endtask

    task automatic do_halt(input logic [3:0] code, input logic [PC_W-1:0] pc);
        halt_req = 1'b1; halt_code = code; halt_pc = pc;
        step();
        halt_req = 1'b0; halt_code = 4'd0;
    endtask

    task automatic t_reset();
        chk("R10", "halted", 32'(halted), 0);
        chk("R10", "wake", 32'(wake), 0);
        chk("R10", "carry", 32'(carry_flag), 0);
        chk("R10", "gie", 32'(gie), 0);
        chk("R10", "pending", 32'(irq_pending), 0);
        chk("R10", "enable", 32'(irq_enable), 0);
    endtask

    task automatic t_noop();
        logic [3:0] codes [4] = '{4'b0000, 4'b0101, 4'b0100, 4'b0001};
        foreach (codes[k]) begin
            do_halt(codes[k], 12'h010);
            step();
            chk("R1", "no-op code halted", 32'(halted), 0);
        end
    endtask

    task automatic t_period();
        int n;
        tmr_sel = 2'd0;
        wait_carry(n);
        clear_carry();
        chk("R4", "carry cleared", 32'(carry_flag), 0);
        wait_carry(n);
        chk("R2", "period sel0", 32'(n + 1), 1000);
        tmr_sel = 2'd1;
        clear_carry();
        wait_carry(n);
        clear_carry();
        wait_carry(n);
        chk("R2", "period sel1", 32'(n + 1), 5000);
        tmr_sel = 2'd0;
        clear_carry();
        wait_carry(n);
        chk("R2", "period back to sel0", 32'(n + 1), 1000);
    endtask

    task automatic t_coincide();
        int n;
        wait_carry(n);
        clear_carry();
        repeat (998) step();
        chk("R4", "carry low before event", 32'(carry_flag), 0);
        carry_test = 1'b1;
        step();
        carry_test = 1'b0;
        chk("R4", "set wins over clear", 32'(carry_flag), 1);
    endtask

    task automatic t_timer_wake();
        int n;
        wait_carry(n);
        clear_carry();
        n = 1;
        do_halt(4'b0010, 12'h123);
        n++;
        chk("R1", "timer halt entered", 32'(halted), 1);
        gie_set = 1'b1; ien_wr = 1'b1; ien_wdata = 4'b0001; irq_req = 4'b0001;
        step(); n++;
        gie_set = 1'b0; ien_wr = 1'b0; irq_req = '0;
        step(); step(); n += 2;
        chk("R8", "timer halt ignores irq", 32'(halted), 1);
        while (wake !== 1'b1 && n < 2000) begin
            step();
            n++;
        end
        chk("R3", "wake at carry interval", 32'(n), 1000);
        chk("R3", "halted dropped", 32'(halted), 0);
        chk("R3", "carry rises with wake", 32'(carry_flag), 1);
        chk("R3", "no vector", 32'(to_vector), 0);
        chk("R3", "resume pc", 32'(resume_pc), 32'h124);
        chk("R3", "ret pc", 32'(ret_pc), 32'h124);
        chk("R8", "irq still pending", 32'(irq_pending), 32'h1);
        step();
        chk("R3", "wake is a pulse", 32'(wake), 0);
        clear_carry();
    endtask

    task automatic t_irq_wake();
        int n;
        gie_clr = 1'b1; ien_wr = 1'b1; ien_wdata = 4'b0110;
        step();
        gie_clr = 1'b0; ien_wr = 1'b0;
        do_halt(4'b1000, 12'h200);
        step(); step();
        chk("R5", "gie off keeps halt", 32'(halted), 1);
        do_halt(4'b1000, 12'h3FF);
        gie_set = 1'b1;
        step();
        gie_set = 1'b0;
        step(); step();
        chk("R5", "disabled pending keeps halt", 32'(halted), 1);
        wait_carry(n);
        step();
        chk("R8", "irq halt ignores carry", 32'(halted), 1);
        clear_carry();
        irq_req = 4'b0110;
        step();
        irq_req = '0;
        n = 0;
        while (wake !== 1'b1 && n < 5) begin
            step();
            n++;
        end
        chk("R6", "irq wake", 32'(wake), 1);
        chk("R6", "to vector", 32'(to_vector), 1);
        chk("R7", "lowest index vector", 32'(resume_pc), 32'(VB + 12'd1));
        chk("R9", "ret pc from first halt", 32'(ret_pc), 32'h201);
        chk("R7", "gie cleared", 32'(gie), 0);
        chk("R7", "pending after ack", 32'(irq_pending), 32'b1101 & 32'b0101 | 32'b0001);
        step();
        do_halt(4'b1000, 12'h050);
        step(); step();
        chk("R5", "gie clear blocks pending", 32'(halted), 1);
        gie_set = 1'b1;
        step();
        gie_set = 1'b0;
        n = 0;
        while (wake !== 1'b1 && n < 5) begin
            step();
            n++;
        end
        chk("R6", "second irq wake", 32'(wake), 1);
        chk("R7", "next source vector", 32'(resume_pc), 32'(VB + 12'd2));
        chk("R6", "second ret pc", 32'(ret_pc), 32'h051);
        chk("R7", "only masked bit left", 32'(irq_pending), 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        tick_1mhz = 1'b1;
        step();
        t_noop();
        t_period();
        t_coincide();
        t_timer_wake();
        t_irq_wake();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule